// File: doc/BRIEF.md
# Floating-Point Reservation Station Array

This block holds a small pool of waiting operations in front of a dynamically scheduled floating-point unit. Each station stores an operation code, two source operands, an immediate/address field and an occupancy flag. An operand is held either as a value or as the number of the station that will produce it. Register names are dropped at issue. Stations are numbered from 1, so a producer tag of 0 always means "value present, or operand not used". For a load, the second operand slot carries the offset as a ready value.

A result bus broadcasts a tag and a value. Every station with a pending operand whose tag equals the broadcast tag copies the value and clears its tag. A station whose operands are both resolved offers itself on the dispatch port. When more than one station is resolved, the one with the lowest index goes first. A station stays occupied after dispatch and only frees when the result bus carries its own tag. The functional units, register file and reorder buffer lie outside the block and appear only as ports.

Issue and dispatch are valid/ready streams. A transfer happens on a clock edge where valid and ready are both high. `iss_ready` is low while every station is occupied, and a request presented then is not written. Once `dsp_valid` is high it stays high, and the offered station does not change, until `dsp_ready` accepts it. The result bus is a plain broadcast and has no ready.

Top module: `fp_rsv_station_array`

## Requirements
- R1: After reset no station is occupied: `iss_ready` is 1, `iss_tag` is 1 and `dsp_valid` is 0.
- R2: An accepted issue writes the lowest-index free station, whose tag is its index plus one and is shown on `iss_tag` before the transfer. With every station occupied, `iss_ready` is 0 and a request with `iss_valid` high writes nothing.
- R3: An operand issued with tag 0 is resolved at once. A station holding a nonzero operand tag is not offered for dispatch.
- R4: When `cdb_valid` is high and `cdb_tag` equals a pending operand tag, that operand takes `cdb_value` and its tag becomes 0. Broadcasts carrying other tags leave the operand pending.
- R5: An operand resolved by a broadcast can be offered for dispatch no earlier than the cycle after the broadcast.
- R6: If an issued operand tag equals the tag broadcast in the same cycle, the station stores the broadcast value as resolved and does not keep the tag.
- R7: Among resolved, not yet dispatched stations, the lowest index is offered. While `dsp_valid` is high and `dsp_ready` is low, the offered station and its fields stay unchanged in the next cycle.
- R8: A dispatched station stays occupied until a broadcast carries its own tag, and becomes free on the following cycle.
- R9: The dispatch port presents the station's tag, operation code, both operand values and the immediate field as stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | A station is free |
| iss_tag | output | TAG_W | Tag the next accepted issue will receive |
| iss_op | input | OP_W | Operation code |
| iss_src1_tag | input | TAG_W | Producer of operand 1 (0 = ready) |
| iss_src1_val | input | DATA_W | Operand 1 value when its tag is 0 |
| iss_src2_tag | input | TAG_W | Producer of operand 2 (0 = ready) |
| iss_src2_val | input | DATA_W | Operand 2 value, or load offset |
| iss_imm | input | IMM_W | Immediate / address field |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | TAG_W | Station whose result is broadcast |
| cdb_value | input | DATA_W | Broadcast result |
| dsp_valid | output | 1 | A resolved station is offered |
| dsp_ready | input | 1 | Functional unit accepts |
| dsp_tag | output | TAG_W | Offered station's tag |
| dsp_op | output | OP_W | Operation code |
| dsp_src1 | output | DATA_W | Operand 1 value |
| dsp_src2 | output | DATA_W | Operand 2 value |
| dsp_imm | output | IMM_W | Immediate / address field |

## Verification
The bench builds the array with four stations, 32-bit data, a 4-bit operation code and a 16-bit immediate. The tag is therefore 3 bits wide, and tag 4 acts both as a station number and as an external producer. Four issues are enough to fill the array, so the full condition is exercised. This also gives three resolved stations and one pending station at once, which tests lowest-index selection against a station that becomes resolved during a back-pressure stall. The same size allows same-cycle issue and broadcast, and broadcasts that match no pending tag.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  // per-station control state
  typedef struct packed {
    logic busy;   // station occupied
    logic sent;   // handed to functional unit, awaiting own result
  } rsv_flags_t;

  localparam int unsigned RSV_READY_TAG = 0;
endpackage

// File: rtl/rsv_pick.sv
module rsv_pick #(
  parameter int unsigned N     = 4,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
        any      = 1'b1;
      end
    end
  end

  // R7: one winner at most, and only among requesters
  always_comb begin
    a_r7_grant_onehot: assert ($onehot0(grant));
    a_r7_grant_subset: assert ((grant & ~req) == '0);
  end
endmodule

// File: rtl/rsv_entry.sv
module rsv_entry
  import rsv_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OP_W   = 4,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned TAG_W  = 3,
  parameter int unsigned MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [OP_W-1:0]   in_op,
  input  logic [TAG_W-1:0]  in_t1,
  input  logic [DATA_W-1:0] in_v1,
  input  logic [TAG_W-1:0]  in_t2,
  input  logic [DATA_W-1:0] in_v2,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              disp_ack,
  output logic              busy,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] v1,
  output logic [DATA_W-1:0] v2,
  output logic [IMM_W-1:0]  imm
);
  localparam logic [TAG_W-1:0] NO_TAG = TAG_W'(RSV_READY_TAG);
  localparam logic [TAG_W-1:0] SELF   = TAG_W'(MY_TAG);

  rsv_flags_t        flags_q;
  logic [TAG_W-1:0]  q1_q, q2_q;
  logic [OP_W-1:0]   op_q;
  logic [DATA_W-1:0] v1_q, v2_q;
  logic [IMM_W-1:0]  imm_q;

  // operand source selection: issue data or stored state, then snoop
  logic [TAG_W-1:0]  t1_src, t2_src, t1_nxt, t2_nxt;
  logic [DATA_W-1:0] d1_src, d2_src, d1_nxt, d2_nxt;
  logic              hit1, hit2, own_done;

  always_comb begin
    t1_src = alloc ? in_t1 : q1_q;
    d1_src = alloc ? in_v1 : v1_q;
    t2_src = alloc ? in_t2 : q2_q;
    d2_src = alloc ? in_v2 : v2_q;
    hit1   = cdb_valid && (t1_src != NO_TAG) && (cdb_tag == t1_src);
    hit2   = cdb_valid && (t2_src != NO_TAG) && (cdb_tag == t2_src);
    t1_nxt = hit1 ? NO_TAG : t1_src;
    d1_nxt = hit1 ? cdb_value : d1_src;
    t2_nxt = hit2 ? NO_TAG : t2_src;
    d2_nxt = hit2 ? cdb_value : d2_src;
    own_done = flags_q.busy && flags_q.sent && cdb_valid && (cdb_tag == SELF);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      q1_q    <= NO_TAG;
      q2_q    <= NO_TAG;
      op_q    <= '0;
      v1_q    <= '0;
      v2_q    <= '0;
      imm_q   <= '0;
    end else begin
      if (alloc) begin
        flags_q.busy <= 1'b1;
        flags_q.sent <= 1'b0;
        op_q         <= in_op;
        imm_q        <= in_imm;
      end else if (own_done) begin
        flags_q <= '0;
      end else if (disp_ack) begin
        flags_q.sent <= 1'b1;
      end
      if (alloc || flags_q.busy) begin
        q1_q <= t1_nxt;
        v1_q <= d1_nxt;
        q2_q <= t2_nxt;
        v2_q <= d2_nxt;
      end
    end
  end

  assign busy  = flags_q.busy;
  assign ready = flags_q.busy && !flags_q.sent && (q1_q == NO_TAG) && (q2_q == NO_TAG);
  assign op    = op_q;
  assign v1    = v1_q;
  assign v2    = v2_q;
  assign imm   = imm_q;

  // R4: snooped match clears the tag and captures the bus value
  a_r4_capture_src1: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.busy && !alloc && q1_q != NO_TAG && cdb_valid && cdb_tag == q1_q)
    |=> (q1_q == NO_TAG && v1_q == $past(cdb_value)));
  a_r4_capture_src2: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.busy && !alloc && q2_q != NO_TAG && cdb_valid && cdb_tag == q2_q)
    |=> (q2_q == NO_TAG && v2_q == $past(cdb_value)));
  // R4: a non-matching broadcast leaves a pending tag alone
  a_r4_keep_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.busy && !alloc && q1_q != NO_TAG && !(cdb_valid && cdb_tag == q1_q))
    |=> $stable(q1_q));
  // R8: own result frees a dispatched station
  a_r8_free_on_own: assert property (@(posedge clk) disable iff (!rst_n)
    (own_done && !alloc) |=> !flags_q.busy);
  // R8: a dispatched station does not free without its own tag
  a_r8_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.busy && !(cdb_valid && cdb_tag == SELF)) |=> flags_q.busy);
  // R6: same-cycle issue and matching broadcast never leaves the tag behind
  a_r6_issue_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && in_t1 != NO_TAG && cdb_valid && cdb_tag == in_t1)
    |=> (q1_q == NO_TAG && v1_q == $past(cdb_value)));
endmodule

// File: rtl/fp_rsv_station_array.sv
module fp_rsv_station_array #(
  parameter int unsigned N_ENTRIES = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned OP_W      = 4,
  parameter int unsigned IMM_W     = 16,
  localparam int unsigned TAG_W    = $clog2(N_ENTRIES + 1),
  localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_src1_tag,
  input  logic [DATA_W-1:0] iss_src1_val,
  input  logic [TAG_W-1:0]  iss_src2_tag,
  input  logic [DATA_W-1:0] iss_src2_val,
  input  logic [IMM_W-1:0]  iss_imm,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  output logic              dsp_valid,
  input  logic              dsp_ready,
  output logic [TAG_W-1:0]  dsp_tag,
  output logic [OP_W-1:0]   dsp_op,
  output logic [DATA_W-1:0] dsp_src1,
  output logic [DATA_W-1:0] dsp_src2,
  output logic [IMM_W-1:0]  dsp_imm
);
  logic [N_ENTRIES-1:0] busy_v, ready_v, free_grant, rdy_grant, sel_grant;
  logic [N_ENTRIES-1:0] alloc_v, ack_v;
  logic [IDX_W-1:0]     free_idx, rdy_idx;
  logic                 any_free, any_rdy;
  logic                 lock_q;
  logic [N_ENTRIES-1:0] lock_grant_q;

  logic [OP_W-1:0]   e_op  [N_ENTRIES];
  logic [DATA_W-1:0] e_v1  [N_ENTRIES];
  logic [DATA_W-1:0] e_v2  [N_ENTRIES];
  logic [IMM_W-1:0]  e_imm [N_ENTRIES];

  rsv_pick #(.N(N_ENTRIES)) u_free_pick (
    .req(~busy_v), .grant(free_grant), .idx(free_idx), .any(any_free));
  rsv_pick #(.N(N_ENTRIES)) u_rdy_pick (
    .req(ready_v), .grant(rdy_grant), .idx(rdy_idx), .any(any_rdy));

  assign iss_ready = any_free;
  assign iss_tag   = TAG_W'(free_idx) + TAG_W'(1);
  assign alloc_v   = (iss_valid && any_free) ? free_grant : '0;

  // a stalled offer is pinned until accepted
  assign sel_grant = lock_q ? lock_grant_q : rdy_grant;
  assign dsp_valid = lock_q || any_rdy;
  assign ack_v     = (dsp_valid && dsp_ready) ? sel_grant : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q       <= 1'b0;
      lock_grant_q <= '0;
    end else begin
      lock_q       <= dsp_valid && !dsp_ready;
      lock_grant_q <= sel_grant;
    end
  end

  generate
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_st
      rsv_entry #(
        .DATA_W(DATA_W), .OP_W(OP_W), .IMM_W(IMM_W), .TAG_W(TAG_W), .MY_TAG(g + 1)
      ) u_entry (
        .clk(clk), .rst_n(rst_n), .alloc(alloc_v[g]),
        .in_op(iss_op), .in_t1(iss_src1_tag), .in_v1(iss_src1_val),
        .in_t2(iss_src2_tag), .in_v2(iss_src2_val), .in_imm(iss_imm),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .disp_ack(ack_v[g]), .busy(busy_v[g]), .ready(ready_v[g]),
        .op(e_op[g]), .v1(e_v1[g]), .v2(e_v2[g]), .imm(e_imm[g]));
    end
  endgenerate

  always_comb begin
    dsp_tag  = '0;
    dsp_op   = '0;
    dsp_src1 = '0;
    dsp_src2 = '0;
    dsp_imm  = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (sel_grant[i]) begin
        dsp_tag  = TAG_W'(i + 1);
        dsp_op   = e_op[i];
        dsp_src1 = e_v1[i];
        dsp_src2 = e_v2[i];
        dsp_imm  = e_imm[i];
      end
    end
  end

  // R7: back-pressure holds the offer
  a_r7_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && !dsp_ready) |=> (dsp_valid && $stable(dsp_tag) && $stable(dsp_src1)
                                   && $stable(dsp_src2) && $stable(dsp_op)));
  // R2: a full array refuses issue and no occupancy is added
  a_r2_full_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!iss_ready) |=> ((busy_v & ~$past(busy_v)) == '0));
  // R3: offered station is never one with a pending operand
  a_r3_offer_resolved: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && !lock_q) |-> ((sel_grant & ready_v) != '0));
  // R2: issue tag is in the station range
  a_r2_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
    iss_ready |-> (iss_tag != '0 && iss_tag <= TAG_W'(N_ENTRIES)));
endmodule

// File: tb/fp_rsv_station_array_tb.sv
module fp_rsv_station_array_tb;
  localparam int unsigned N = 4, DW = 32, OW = 4, IW = 16;
  localparam int unsigned TW = $clog2(N + 1);

  logic clk = 0, rst_n = 0;
  logic iss_valid = 0, iss_ready;
  logic [TW-1:0] iss_tag;
  logic [OW-1:0] iss_op = 0;
  logic [TW-1:0] iss_src1_tag = 0, iss_src2_tag = 0;
  logic [DW-1:0] iss_src1_val = 0, iss_src2_val = 0;
  logic [IW-1:0] iss_imm = 0;
  logic cdb_valid = 0;
  logic [TW-1:0] cdb_tag = 0;
  logic [DW-1:0] cdb_value = 0;
  logic dsp_valid, dsp_ready = 0;
  logic [TW-1:0] dsp_tag;
  logic [OW-1:0] dsp_op;
  logic [DW-1:0] dsp_src1, dsp_src2;
  logic [IW-1:0] dsp_imm;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  fp_rsv_station_array #(.N_ENTRIES(N), .DATA_W(DW), .OP_W(OW), .IMM_W(IW)) u_dut (
    .clk, .rst_n, .iss_valid, .iss_ready, .iss_tag, .iss_op,
    .iss_src1_tag, .iss_src1_val, .iss_src2_tag, .iss_src2_val, .iss_imm,
    .cdb_valid, .cdb_tag, .cdb_value, .dsp_valid, .dsp_ready, .dsp_tag,
    .dsp_op, .dsp_src1, .dsp_src2, .dsp_imm);

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // inputs change just after the falling edge; outputs are read 1 ns later
  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic idle();
    iss_valid = 0; cdb_valid = 0; dsp_ready = 0;
  endtask

  task automatic drive_issue(int op, int t1, int v1, int t2, int v2, int imm);
    iss_valid = 1; iss_op = OW'(op);
    iss_src1_tag = TW'(t1); iss_src1_val = DW'(v1);
    iss_src2_tag = TW'(t2); iss_src2_val = DW'(v2); iss_imm = IW'(imm);
  endtask

  task automatic drive_cdb(int tag, int val);
    cdb_valid = 1; cdb_tag = TW'(tag); cdb_value = DW'(val);
  endtask

  task automatic t_reset();
    settle();
    chk("R1 iss_ready", iss_ready, 1);
    chk("R1 iss_tag", iss_tag, 1);
    chk("R1 dsp_valid", dsp_valid, 0);
  endtask

  task automatic t_ready_issue();
    drive_issue(3, 0, 10, 0, 20, 5);
    settle(); idle();
    chk("R2 next tag after first issue", iss_tag, 2);
    chk("R3 ready operands offered", dsp_valid, 1);
    chk("R9 dsp_tag", dsp_tag, 1);
    chk("R9 dsp_op", dsp_op, 3);
    chk("R9 dsp_src1", dsp_src1, 10);
    chk("R9 dsp_src2", dsp_src2, 20);
    chk("R9 dsp_imm", dsp_imm, 5);
    dsp_ready = 1;
    settle(); idle();
    chk("R8 no re-offer after dispatch", dsp_valid, 0);
    chk("R8 station stays busy", iss_tag, 2);
    drive_cdb(1, 0);
    settle(); idle();
    chk("R8 freed by own tag", iss_tag, 1);
  endtask

  task automatic t_wait_capture();
    drive_issue(5, 3, 0, 0, 7, 0);
    settle(); idle();
    chk("R3 pending tag not offered", dsp_valid, 0);
    drive_cdb(2, 99);
    settle(); idle();
    chk("R4 other tag ignored", dsp_valid, 0);
    drive_cdb(3, 55);
    #1 chk("R5 not offered in broadcast cycle", dsp_valid, 0);
    settle(); idle();
    chk("R5 offered cycle after broadcast", dsp_valid, 1);
    chk("R4 captured value", dsp_src1, 55);
    chk("R4 ready operand kept", dsp_src2, 7);
    dsp_ready = 1;
    settle(); idle();
    drive_cdb(1, 0);
    settle(); idle();
    chk("R8 freed", iss_tag, 1);
  endtask

  task automatic t_same_cycle();
    drive_issue(6, 4, 0, 0, 1, 0);
    drive_cdb(4, 77);
    settle(); idle();
    chk("R6 bypass makes station ready", dsp_valid, 1);
    chk("R6 bypass value", dsp_src1, 77);
    dsp_ready = 1;
    settle(); idle();
    drive_cdb(1, 0);
    settle(); idle();
    chk("R6 freed", iss_tag, 1);
  endtask

  task automatic t_priority();
    drive_issue(1, 4, 0, 0, 11, 0); settle();
    drive_issue(2, 0, 2, 0, 12, 0); settle();
    drive_issue(3, 0, 3, 0, 13, 0); settle();
    drive_issue(4, 0, 4, 0, 14, 0); settle(); idle();
    chk("R2 full array not ready", iss_ready, 0);
    drive_issue(9, 0, 9, 0, 9, 9);
    chk("R7 lowest ready offered", dsp_tag, 2);
    drive_cdb(4, 44);
    settle(); idle();
    chk("R7 offer held under stall", dsp_tag, 2);
    chk("R7 offer data held", dsp_src1, 2);
    dsp_ready = 1;
    settle();
    chk("R7 lowest after accept", dsp_tag, 1);
    chk("R4 captured while stalled", dsp_src1, 44);
    settle();
    chk("R7 next in order", dsp_tag, 3);
    settle();
    chk("R7 last in order", dsp_tag, 4);
    settle(); idle();
    chk("R8 all dispatched", dsp_valid, 0);
    for (int t = 1; t <= 4; t++) begin
      drive_cdb(t, 0); settle();
    end
    idle(); settle();
    chk("R2 freed array ready", iss_ready, 1);
    chk("R2 refused issue left nothing", dsp_valid, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        t_reset();
        t_ready_issue();
        t_wait_capture();
        t_same_cycle();
        t_priority();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule